// File: doc/BRIEF.md
# Host Command Register Interface

This block is the host-facing register file and command handshake of a disk controller. A host accesses it through a 3-bit address, separate active-low read and write strobes and an 8-bit data bus with an optional even-parity bit. Both strobes are synchronized into the system clock. Each register action happens exactly once per strobe, on its synchronized falling edge. Writes load a command register, a data port and six parameter registers. Reads return a status byte, the data port and six result registers.

A command write raises busy while the block validates the command against the drive number it names. The drive number comes from parameter 0. A valid command goes to the execution backend as a one-cycle pulse that carries the opcode and a snapshot of all parameters. A rejected command instead posts an error completion. The backend reports the end of a command with a one-cycle done pulse that carries a drive number, a 6-bit status and five result bytes.

Every completion sets the completion-request status bit and, once interrupts are enabled, drives a level interrupt. Writing opcode 0x00 acknowledges the completion. This clears the request and enables interrupts. After reset the block posts a fixed power-up completion that raises no interrupt. Disk data buffering sits outside the block: data-port accesses appear only as strobes.

Top module: `host_cmd_regif`

## Requirements
- R1: Address map (hostAddr): for reads, 0 returns the status byte, 1 returns rdDataIn, and 2 to 7 return result 0 to 5. For writes, 0 loads the command, 1 pulses dataWrStrobe, and 2 to 7 load parameter 0 to 5.
- R2: A command write with a nonzero opcode sets status bit 3 (busy) for VALIDATE_CYCLES cycles. An accepted command then clears busy and pulses cmdValid for one cycle. During that pulse, cmdOpcode holds the opcode and cmdParams holds parameter k in bits 8k+7:8k.
- R3: A write to the command register or to a parameter register while busy aborts the pending command and is itself discarded. The block then posts status 0x38, and no cmdValid follows.
- R4: If bits 2:0 of parameter 0 hold a value of DRIVES or more, the command is rejected with status 0x35 and no cmdValid.
- R5: A drive stays occupied from the acceptance of its command until a done pulse for that drive. A command to an occupied drive is rejected with status 0x37.
- R6: Status byte layout: bit 7 is reject, bit 6 is completion request, bit 5 is special completion, bit 4 reads 0, bit 3 is busy, bit 2 is xferReqIn, bit 1 is xferDirIn and bit 0 is busEnIn.
- R7: Result 0 holds the drive in bits 7:6 and the 6-bit status in bits 5:0. The status splits into a type in bits 5:4 and a code in bits 3:0. A done pulse loads result 0 with {doneDrive, doneStatus} and loads results 1 to 5 from doneResults bytes 0 to 4. A local error posts {parameter 0 bits 1:0, code}, sets reject and leaves results 1 to 5 unchanged.
- R8: hostIrqN is low exactly while completion request is set and interrupts are enabled. Writing opcode 0x00 when not busy clears completion request, reject and special, and enables interrupts.
- R9: After reset, completion request is set and result 0 to 5 read 0x16, 0xAA, 0x55, 0xF0, 0x0F and 0x00. hostIrqN stays high until the first acknowledge.
- R10: While parityEn is high, a write whose 8 data bits plus hostParIn have odd parity is discarded. It aborts any pending command and posts status 0x1C. On reads, hostParOut gives the 9 bits even parity.
- R11: Each low period of a strobe causes one action, whatever its length. A data-port read pulses dataRdStrobe once.
- R12: A done pulse copies doneSpecial into the special completion bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| hostAddr | input | 3 | Register address |
| hostRdN | input | 1 | Active-low read strobe |
| hostWrN | input | 1 | Active-low write strobe |
| hostDataIn | input | 8 | Host write data |
| hostParIn | input | 1 | Host write parity bit |
| hostDataOut | output | 8 | Read data for the addressed register |
| hostParOut | output | 1 | Even-parity bit for hostDataOut |
| hostIrqN | output | 1 | Active-low level interrupt |
| parityEn | input | 1 | Enables the write parity check |
| xferReqIn | input | 1 | Data transfer request, mirrored in status |
| xferDirIn | input | 1 | Transfer direction (1 means host read), mirrored in status |
| busEnIn | input | 1 | Data bus enable, mirrored in status |
| rdDataIn | input | 8 | Byte returned on data-port reads |
| dataRdStrobe | output | 1 | One-cycle pulse per data-port read |
| dataWrStrobe | output | 1 | One-cycle pulse per accepted data-port write |
| cmdValid | output | 1 | One-cycle pulse for an accepted command |
| cmdOpcode | output | 8 | Opcode of the accepted command |
| cmdParams | output | 48 | Parameter snapshot, parameter k in bits 8k+7:8k |
| doneValid | input | 1 | One-cycle completion pulse from the backend |
| doneDrive | input | 2 | Drive of the completed command |
| doneStatus | input | 6 | Completion type and code |
| doneSpecial | input | 1 | Completion is a special one |
| doneResults | input | 40 | Result bytes 1 to 5, result 1 in bits 7:0 |

## Verification
A wrong busy or drive-occupancy state shows up at the ports within one validation window after the next command write. It appears either as a cmdValid pulse that should not occur, or as a missing one, and result 0 then holds the wrong 0x35, 0x37 or 0x38 code. A wrong completion or interrupt-enable state shows up as soon as the status byte and hostIrqN are read after a post or an acknowledge. The bench checks the parameter snapshot after a discarded write, which proves at the ports that the discarded byte never reached the register.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  localparam int DataW     = 8;
  localparam int AddrW     = 3;
  localparam int NumRegs   = 6;
  localparam int MaxDrives = 4;

  localparam logic [5:0] StInit      = 6'h16;
  localparam logic [5:0] StParity    = 6'h1C;
  localparam logic [5:0] StBadDrive  = 6'h35;
  localparam logic [5:0] StDriveBusy = 6'h37;
  localparam logic [5:0] StDoubleWr  = 6'h38;
  localparam logic [7:0] OpAck       = 8'h00;

  localparam logic [AddrW-1:0] AddrCtl  = 3'd0;
  localparam logic [AddrW-1:0] AddrData = 3'd1;

  typedef struct packed {
    logic             paramWe;
    logic [AddrW-1:0] paramIdx;
    logic             postLocal;
    logic [7:0]       localRes0;
    logic             postBackend;
  } dpStrobeT;
endpackage

// File: rtl/hcr_strobe_sync.sv
module hcr_strobe_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] strobeN,
  output logic [LINES-1:0] fallPulse
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES:0] shiftQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shiftQ <= '1;
      else       shiftQ <= {shiftQ[STAGES-1:0], strobeN[i]};
    end
    assign fallPulse[i] = shiftQ[STAGES] & ~shiftQ[STAGES-1];

    // R11: one action per low period
    a_r11_single_action: assert property (@(posedge clk) disable iff (!rstN)
      fallPulse[i] |=> !fallPulse[i]);
  end
endmodule

// File: rtl/hcr_datapath.sv
module hcr_datapath
  import hcr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobeT               ctl,
  input  logic [DataW-1:0]       wrData,
  input  logic [AddrW-1:0]       addr,
  input  logic [7:0]             statusByte,
  input  logic [DataW-1:0]       rdDataIn,
  input  logic [1:0]             doneDrive,
  input  logic [5:0]             doneStatus,
  input  logic [5*DataW-1:0]     doneResults,
  output logic [DataW-1:0]       dataOut,
  output logic                   parOut,
  output logic [NumRegs*DataW-1:0] paramFlat
);
  logic [DataW-1:0] paramReg  [NumRegs];
  logic [DataW-1:0] resultReg [NumRegs];

  function automatic logic [DataW-1:0] initByte(int idx);
    case (idx)
      0:       return {2'b00, StInit};
      1:       return 8'hAA;
      2:       return 8'h55;
      3:       return 8'hF0;
      4:       return 8'h0F;
      default: return 8'h00;
    endcase
  endfunction

  for (genvar i = 0; i < NumRegs; i++) begin : g_regs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) paramReg[i] <= '0;
      else if (ctl.paramWe && ctl.paramIdx == AddrW'(i)) paramReg[i] <= wrData;
    end
    assign paramFlat[i*DataW +: DataW] = paramReg[i];

    if (i == 0) begin : g_res0
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                resultReg[0] <= initByte(0);
        else if (ctl.postLocal)   resultReg[0] <= ctl.localRes0;
        else if (ctl.postBackend) resultReg[0] <= {doneDrive, doneStatus};
      end
    end else begin : g_resN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) resultReg[i] <= initByte(i);
        else if (ctl.postBackend && !ctl.postLocal)
          resultReg[i] <= doneResults[(i-1)*DataW +: DataW];
      end
    end
  end

  always_comb begin
    case (addr)
      AddrCtl:  dataOut = statusByte;
      AddrData: dataOut = rdDataIn;
      default:  dataOut = resultReg[addr - 3'd2];
    endcase
  end
  assign parOut = ^dataOut;

  // R7: the two post sources never collide
  a_r7_single_post: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.postLocal && ctl.postBackend));
endmodule

// File: rtl/hcr_ctrl.sv
module hcr_ctrl
  import hcr_pkg::*;
#(
  parameter int DRIVES          = 4,
  parameter int VALIDATE_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrFall,
  input  logic             rdFall,
  input  logic [AddrW-1:0] addr,
  input  logic [DataW-1:0] wrData,
  input  logic             wrPar,
  input  logic             parityEn,
  input  logic [2:0]       param0Low,
  input  logic             doneValid,
  input  logic [1:0]       doneDrive,
  input  logic             doneSpecial,
  input  logic             xferReqIn,
  input  logic             xferDirIn,
  input  logic             busEnIn,
  output dpStrobeT         ctl,
  output logic [7:0]       statusByte,
  output logic             irqN,
  output logic             cmdValid,
  output logic [DataW-1:0] cmdOpcode,
  output logic             dataRdStrobe,
  output logic             dataWrStrobe
);
  localparam int CntW = $clog2(VALIDATE_CYCLES + 1);

  logic            busy, compReq, reject, special, irqEn;
  logic [CntW-1:0] busyCnt;
  logic [DataW-1:0] pendOp;
  logic [MaxDrives-1:0] driveActive;

  logic parityBad, wrCmd, wrParam, abortNow, finishNow, acceptNow, ackNow, startNow;
  logic [5:0] errCode;
  logic badDrive;

  assign parityBad = parityEn && (^{wrPar, wrData});
  assign wrCmd     = wrFall && addr == AddrCtl && !parityBad;
  assign wrParam   = wrFall && addr > AddrData && !parityBad;
  assign abortNow  = (wrFall && parityBad) || (busy && (wrCmd || wrParam));
  assign finishNow = busy && busyCnt == '0 && !abortNow;
  assign badDrive  = int'(param0Low) >= DRIVES;
  assign acceptNow = finishNow && !badDrive && !driveActive[param0Low[1:0]];
  assign ackNow    = wrCmd && !busy && wrData == OpAck;
  assign startNow  = wrCmd && !busy && wrData != OpAck;

  always_comb begin
    errCode = StDoubleWr;
    if (wrFall && parityBad) errCode = StParity;
    else if (abortNow)       errCode = StDoubleWr;
    else if (badDrive)       errCode = StBadDrive;
    else                     errCode = StDriveBusy;
    ctl             = '0;
    ctl.paramWe     = wrParam && !busy;
    ctl.paramIdx    = addr - 3'd2;
    ctl.postLocal   = abortNow || (finishNow && !acceptNow);
    ctl.localRes0   = {param0Low[1:0], errCode};
    ctl.postBackend = doneValid && !ctl.postLocal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; busyCnt <= '0; pendOp <= '0;
      compReq <= 1'b1; reject <= 1'b0; special <= 1'b0; irqEn <= 1'b0;
      driveActive <= '0; cmdValid <= 1'b0;
      dataRdStrobe <= 1'b0; dataWrStrobe <= 1'b0;
    end else begin
      cmdValid     <= acceptNow;
      dataRdStrobe <= rdFall && addr == AddrData;
      dataWrStrobe <= wrFall && addr == AddrData && !parityBad;
      if (doneValid && int'(doneDrive) < DRIVES) driveActive[doneDrive] <= 1'b0;
      if (acceptNow) driveActive[param0Low[1:0]] <= 1'b1;
      if (ackNow) begin
        compReq <= 1'b0; reject <= 1'b0; special <= 1'b0; irqEn <= 1'b1;
      end
      if (startNow) begin
        busy <= 1'b1; busyCnt <= CntW'(VALIDATE_CYCLES - 1); pendOp <= wrData;
      end else if (busy && busyCnt != '0) begin
        busyCnt <= busyCnt - 1'b1;
      end
      if (finishNow || abortNow) busy <= 1'b0;
      if (ctl.postLocal) begin
        compReq <= 1'b1; reject <= 1'b1; special <= 1'b0;
      end else if (ctl.postBackend) begin
        compReq <= 1'b1; reject <= 1'b0; special <= doneSpecial;
      end
    end
  end

  assign statusByte = {reject, compReq, special, 1'b0, busy, xferReqIn, xferDirIn, busEnIn};
  assign irqN       = ~(compReq & irqEn);
  assign cmdOpcode  = pendOp;

  // R2: a command leaves only at the end of a busy window
  a_r2_accept_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $past(busy) && !busy);
  // R5: an accepted drive is marked occupied
  a_r5_drive_marked: assert property (@(posedge clk) disable iff (!rstN)
    (acceptNow && !doneValid) |=> driveActive[$past(param0Low[1:0])]);
  // R3: an error post never coincides with a forwarded command
  a_r3_abort_no_cmd: assert property (@(posedge clk) disable iff (!rstN)
    ctl.postLocal |=> !cmdValid);
  // R8: acknowledge clears the request
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ackNow && !doneValid) |=> !compReq && !irqEn == 1'b0);
endmodule

// File: rtl/host_cmd_regif.sv
module host_cmd_regif
  import hcr_pkg::*;
#(
  parameter int DRIVES          = 4,
  parameter int VALIDATE_CYCLES = 16,
  parameter int SYNC_STAGES     = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  hostAddr,
  input  logic        hostRdN,
  input  logic        hostWrN,
  input  logic [7:0]  hostDataIn,
  input  logic        hostParIn,
  output logic [7:0]  hostDataOut,
  output logic        hostParOut,
  output logic        hostIrqN,
  input  logic        parityEn,
  input  logic        xferReqIn,
  input  logic        xferDirIn,
  input  logic        busEnIn,
  input  logic [7:0]  rdDataIn,
  output logic        dataRdStrobe,
  output logic        dataWrStrobe,
  output logic        cmdValid,
  output logic [7:0]  cmdOpcode,
  output logic [47:0] cmdParams,
  input  logic        doneValid,
  input  logic [1:0]  doneDrive,
  input  logic [5:0]  doneStatus,
  input  logic        doneSpecial,
  input  logic [39:0] doneResults
);
  logic [1:0] fallPulse;
  dpStrobeT   ctl;
  logic [7:0] statusByte;

  hcr_strobe_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk(clk), .rstN(rstN), .strobeN({hostWrN, hostRdN}), .fallPulse(fallPulse));

  hcr_ctrl #(.DRIVES(DRIVES), .VALIDATE_CYCLES(VALIDATE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrFall(fallPulse[1]), .rdFall(fallPulse[0]),
    .addr(hostAddr), .wrData(hostDataIn), .wrPar(hostParIn), .parityEn(parityEn),
    .param0Low(cmdParams[2:0]), .doneValid(doneValid), .doneDrive(doneDrive),
    .doneSpecial(doneSpecial), .xferReqIn(xferReqIn), .xferDirIn(xferDirIn),
    .busEnIn(busEnIn), .ctl(ctl), .statusByte(statusByte), .irqN(hostIrqN),
    .cmdValid(cmdValid), .cmdOpcode(cmdOpcode), .dataRdStrobe(dataRdStrobe),
    .dataWrStrobe(dataWrStrobe));

  hcr_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(hostDataIn), .addr(hostAddr),
    .statusByte(statusByte), .rdDataIn(rdDataIn), .doneDrive(doneDrive),
    .doneStatus(doneStatus), .doneResults(doneResults), .dataOut(hostDataOut),
    .parOut(hostParOut), .paramFlat(cmdParams));

  // R8: the interrupt only accompanies a pending completion
  a_r8_irq_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    !hostIrqN |-> statusByte[6]);
endmodule

// File: tb/tb_host_cmd_regif.sv
module tb_host_cmd_regif;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] hostAddr = '0;
  logic hostRdN = 1'b1, hostWrN = 1'b1;
  logic [7:0] hostDataIn = '0;
  logic hostParIn = 1'b0;
  logic [7:0] hostDataOut;
  logic hostParOut, hostIrqN;
  logic parityEn = 1'b0, xferReqIn = 1'b0, xferDirIn = 1'b0, busEnIn = 1'b1;
  logic [7:0] rdDataIn = 8'h5A;
  logic dataRdStrobe, dataWrStrobe, cmdValid;
  logic [7:0] cmdOpcode;
  logic [47:0] cmdParams;
  logic doneValid = 1'b0;
  logic [1:0] doneDrive = '0;
  logic [5:0] doneStatus = '0;
  logic doneSpecial = 1'b0;
  logic [39:0] doneResults = '0;

  int checks = 0, errors = 0;
  int cmdCnt = 0, rdCnt = 0, wrCnt = 0;
  logic [7:0] lastOp;
  logic [47:0] lastParams;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  host_cmd_regif dut (.*);

  always @(negedge clk) begin
    if (cmdValid) begin cmdCnt++; lastOp = cmdOpcode; lastParams = cmdParams; end
    if (dataRdStrobe) rdCnt++;
    if (dataWrStrobe) wrCnt++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [7:0] d, input bit goodPar = 1);
    @(negedge clk);
    hostAddr = a; hostDataIn = d; hostParIn = goodPar ? ^d : ~^d; hostWrN = 1'b0;
    repeat (4) @(negedge clk);
    hostWrN = 1'b1;
    @(negedge clk);
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = a;
    #1 d = hostDataOut;
  endtask

  task automatic backendDone(input logic [1:0] drv, input logic [5:0] st,
                             input logic sp, input logic [39:0] res);
    @(negedge clk);
    doneValid = 1'b1; doneDrive = drv; doneStatus = st; doneSpecial = sp; doneResults = res;
    @(negedge clk);
    doneValid = 1'b0;
    idle(2);
  endtask

  task automatic ack();
    hostWrite(3'd0, 8'h00);
    idle(3);
  endtask

  initial begin
    fork
      begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
      begin : main
        idle(5); rstN = 1'b1; idle(5);
        // R9 / R6: power-up state
        peek(3'd0, v); chk("R9 status after reset", v, 8'h41);
        chk("R9 no irq before ack", hostIrqN, 1'b1);
        for (int i = 0; i < 6; i++) begin
          logic [7:0] expB;
          case (i) 0: expB = 8'h16; 1: expB = 8'hAA; 2: expB = 8'h55;
                   3: expB = 8'hF0; 4: expB = 8'h0F; default: expB = 8'h00; endcase
          peek(3'(i + 2), v); chk("R9 R1 reset result", v, expB);
        end
        ack();
        peek(3'd0, v); chk("R8 ack clears request", v, 8'h01);
        chk("R8 irq idle", hostIrqN, 1'b1);

        // R2: accepted command
        hostWrite(3'd2, 8'h01);
        for (int i = 1; i < 6; i++) hostWrite(3'(i + 2), 8'(8'h11 * i));
        hostWrite(3'd0, 8'h42);
        peek(3'd0, v); chk("R2 busy set", v, 8'h09);
        idle(25);
        chk("R2 one cmdValid", cmdCnt, 1);
        chk("R2 opcode", lastOp, 8'h42);
        chk("R2 param snapshot", lastParams, 48'h554433221101);
        peek(3'd0, v); chk("R2 busy cleared, no completion", v, 8'h01);

        // R5: occupied drive
        hostWrite(3'd0, 8'h45); idle(25);
        peek(3'd2, v); chk("R5 drive busy code", v, 8'h77);
        chk("R5 no cmdValid", cmdCnt, 1);
        peek(3'd0, v); chk("R6 reject status", v, 8'hC1);
        chk("R8 irq asserted", hostIrqN, 1'b0);
        ack();
        chk("R8 irq cleared by ack", hostIrqN, 1'b1);

        // R7 / R12: backend completion
        backendDone(2'd1, 6'h00, 1'b0, 40'h0504030201);
        peek(3'd2, v); chk("R7 result0", v, 8'h40);
        for (int i = 1; i < 6; i++) begin
          peek(3'(i + 2), v); chk("R7 result bytes", v, 8'(i));
        end
        peek(3'd0, v); chk("R7 completion status", v, 8'h41);
        chk("R8 irq on completion", hostIrqN, 1'b0);
        ack();
        hostWrite(3'd0, 8'h42); idle(25);
        chk("R5 drive freed by done", cmdCnt, 2);
        backendDone(2'd1, 6'h00, 1'b0, 40'h0); ack();

        // R4: drive number out of range
        hostWrite(3'd2, 8'h05); hostWrite(3'd0, 8'h42); idle(25);
        peek(3'd2, v); chk("R4 bad drive code", v, 8'h75);
        chk("R4 no cmdValid", cmdCnt, 2);
        ack();

        // R3: writes while busy
        hostWrite(3'd2, 8'h00); hostWrite(3'd0, 8'h42); hostWrite(3'd3, 8'h99); idle(25);
        peek(3'd2, v); chk("R3 param write while busy", v, 8'h38);
        chk("R3 no cmdValid", cmdCnt, 2);
        peek(3'd0, v); chk("R3 reject status", v, 8'hC1);
        ack();
        hostWrite(3'd0, 8'h42); hostWrite(3'd0, 8'h43); idle(25);
        peek(3'd2, v); chk("R3 double command write", v, 8'h38);
        chk("R3 no cmdValid on double write", cmdCnt, 2);
        ack();

        // R10: parity
        parityEn = 1'b1;
        hostWrite(3'd2, 8'h02, 0); idle(3);
        peek(3'd2, v); chk("R10 bad parity code", v, 8'h1C);
        ack();
        hostWrite(3'd2, 8'h02); hostWrite(3'd0, 8'h42); idle(25);
        chk("R10 good parity accepted", cmdCnt, 3);
        chk("R3 R10 discarded writes left params", lastParams, 48'h554433221102);
        for (int a = 1; a < 8; a++) begin
          peek(3'(a), v); chk("R10 read parity even", hostParOut ^ (^v), 1'b0);
        end
        hostWrite(3'd1, 8'h3C, 0); idle(3);
        chk("R10 bad-parity data write dropped", wrCnt, 0);
        peek(3'd2, v); chk("R10 parity code with drive", v, 8'h9C);
        ack();
        hostWrite(3'd1, 8'h3C); idle(3);
        chk("R1 data write strobe", wrCnt, 1);

        // R12: special completion
        backendDone(2'd2, 6'h03, 1'b1, 40'h0);
        peek(3'd0, v); chk("R12 special bit", v, 8'h61);
        peek(3'd2, v); chk("R12 result0", v, 8'h83);
        ack();
        peek(3'd0, v); chk("R12 ack clears special", v, 8'h01);

        // R11 / R1: long data-port read
        @(negedge clk); hostAddr = 3'd1; hostRdN = 1'b0;
        repeat (10) @(negedge clk);
        chk("R1 data port read", hostDataOut, 8'h5A);
        hostRdN = 1'b1; idle(5);
        chk("R11 one read strobe", rdCnt, 1);

        // R6: mirrored inputs
        xferReqIn = 1'b1; xferDirIn = 1'b1;
        peek(3'd0, v); chk("R6 mirrored bits", v, 8'h07);
        disable watchdog;
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule